// File: doc/BRIEF.md
# Dual Product Rounding Shifter

This block forms two signed products from two pairs of XLEN-bit operands and scales both by the same right shift. Each product is kept at its full double width, 2*XLEN bits. When the shift count is nonzero, half of one unit in the last kept place is added to the product. The sum is then shifted right arithmetically, and the low XLEN bits of the shifted value become the result. When the shift count is zero, the low half of each product passes straight through and no rounding constant is added.

Both lanes share one shift count and run through the same datapath. Their results go to two separate outputs, `rt` for the first pair and `rs` for the second. Every value passes through one output register, so a result is visible one clock after its operands were presented. The rounding path is the same for every XLEN, and 64 gets no special case. The rounding add wraps inside the 2*XLEN-bit adder and is never saturated.

Top module: `dual_round_shift`

## Requirements
- R1: While `rst_n` is low, `rt` and `rs` are held at zero.
- R2: The inputs present at a rising clock edge determine `rt` and `rs` from that edge until the next one, which is a latency of exactly one clock.
- R3: When `shamt` is 0, `rt` is the low XLEN bits of the signed product `op1_a*op1_b`, `rs` is the low XLEN bits of `op2_a*op2_b`, and no rounding constant is added.
- R4: When `shamt` is n, with n from 1 to XLEN-1, each result is the low XLEN bits of (P + 2^(n-1)) shifted right arithmetically by n. Here P is the product at 2*XLEN bits, so a tie rounds toward plus infinity (for example P=1, n=1 gives 1).
- R5: The bits shifted in from the top are copies of the most significant bit of the 2*XLEN-bit rounded sum. So P=-3 with n=1 gives all ones, and P=-1 with n=1 gives 0.
- R6: Both operands are signed two's complement, and the product is fully sign-extended to 2*XLEN bits. For example, (-1)*(-1) with n=0 gives 1, and a product of 2^(2*XLEN-2) is represented exactly.
- R7: The two lanes apply the same procedure and do not affect each other. Equal operand pairs give equal results, and a zero operand in a lane gives 0 in that lane for every n.
- R8: `shamt` is an unsigned field of clog2(XLEN) bits, and every value from 0 to XLEN-1 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op1_a | input | XLEN | First lane, multiplicand (signed) |
| op1_b | input | XLEN | First lane, multiplier (signed) |
| op2_a | input | XLEN | Second lane, multiplicand (signed) |
| op2_b | input | XLEN | Second lane, multiplier (signed) |
| shamt | input | clog2(XLEN) | Right shift count shared by both lanes |
| rt | output | XLEN | Registered result of the first lane |
| rs | output | XLEN | Registered result of the second lane |

## Verification
Both results are due one rising edge after their operands are applied. The bench drives each operand set on a falling edge and pushes the expected pair into a queue. On the next falling edge it pops that pair and compares it with the outputs, so every comparison falls half a period after the edge that loaded the register. The expected values come from a behavioural formula evaluated at 128-bit width. The vectors cover directed ties, signed corner products and random operands for every shift count.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
    localparam int unsigned NUM_LANES = 2;

    typedef enum logic [0:0] {
        LANE_T = 1'b0,
        LANE_S = 1'b1
    } lane_e;
endpackage

// File: rtl/rsh_mul.sv
module rsh_mul #(
    parameter int unsigned XLEN = 64,
    localparam int unsigned PW  = 2 * XLEN
) (
    input  logic [XLEN-1:0] mul_a,
    input  logic [XLEN-1:0] mul_b,
    output logic [PW-1:0]   mul_p
);
    logic signed [PW-1:0] ext_a;
    logic signed [PW-1:0] ext_b;

    always_comb begin
        ext_a = $signed({{XLEN{mul_a[XLEN-1]}}, mul_a});
        ext_b = $signed({{XLEN{mul_b[XLEN-1]}}, mul_b});
        mul_p = ext_a * ext_b;
    end
endmodule

// File: rtl/rsh_rndshift.sv
module rsh_rndshift #(
    parameter int unsigned XLEN = 64,
    localparam int unsigned PW  = 2 * XLEN,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic [PW-1:0]   full_p,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);
    logic [PW-1:0]        bias;
    logic [PW-1:0]        sum;
    logic signed [PW-1:0] scaled;

    always_comb begin
        bias   = '0;
        if (shamt != '0) begin
            bias = {{(PW-1){1'b0}}, 1'b1} << (shamt - 1'b1);
        end
        sum    = full_p + bias;
        scaled = $signed(sum) >>> shamt;
        if (shamt == '0) begin
            res = full_p[XLEN-1:0];
        end else begin
            res = scaled[XLEN-1:0];
        end
    end
endmodule

// File: rtl/dual_round_shift.sv
module dual_round_shift #(
    parameter int unsigned XLEN = 64,
    localparam int unsigned PW  = 2 * XLEN,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] op1_a,
    input  logic [XLEN-1:0] op1_b,
    input  logic [XLEN-1:0] op2_a,
    input  logic [XLEN-1:0] op2_b,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] rt,
    output logic [XLEN-1:0] rs
);
    import rsh_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0] rt;
        logic [XLEN-1:0] rs;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_LANES-1:0][XLEN-1:0] lane_a;
    logic [NUM_LANES-1:0][XLEN-1:0] lane_b;
    logic [NUM_LANES-1:0][PW-1:0]   lane_p;
    logic [NUM_LANES-1:0][XLEN-1:0] lane_r;

    assign lane_a[LANE_T] = op1_a;
    assign lane_b[LANE_T] = op1_b;
    assign lane_a[LANE_S] = op2_a;
    assign lane_b[LANE_S] = op2_b;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        rsh_mul #(.XLEN(XLEN)) u_mul (
            .mul_a (lane_a[g]),
            .mul_b (lane_b[g]),
            .mul_p (lane_p[g])
        );
        rsh_rndshift #(.XLEN(XLEN)) u_rs (
            .full_p (lane_p[g]),
            .shamt  (shamt),
            .res    (lane_r[g])
        );
    end

    always_comb begin
        state_d    = state_q;
        state_d.rt = lane_r[LANE_T];
        state_d.rs = lane_r[LANE_S];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rt = state_q.rt;
    assign rs = state_q.rs;

    // Set after the first clock out of reset; used only to qualify $past.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (!$past(rst_n) -> (rt == '0 && rs == '0)));

    // R3
    bypass_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && shamt == '0) |=>
            (rt == $past(op1_a * op1_b) && rs == $past(op2_a * op2_b)));

    // R7
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (op1_a == '0 || op1_b == '0)) |=> (rt == '0));

    // R7
    lanes_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && op1_a == op2_a && op1_b == op2_b) |=> (rt == rs));

    // R6
    neg_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && shamt == '0 && (&op1_a) && (&op1_b))
            |=> (rt == XLEN'(1)));
endmodule

// File: tb/dual_round_shift_test.sv
`timescale 1ns/1ps
module dual_round_shift_test;
    localparam int XLEN = 64;
    localparam int SHW  = $clog2(XLEN);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] op1_a, op1_b, op2_a, op2_b;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] rt, rs;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [XLEN-1:0] exp_t_q[$];
    logic [XLEN-1:0] exp_s_q[$];
    string           tag_q[$];

    always #2.5 clk = ~clk;

    dual_round_shift #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .op1_a(op1_a), .op1_b(op1_b), .op2_a(op2_a), .op2_b(op2_b),
        .shamt(shamt), .rt(rt), .rs(rs)
    );

    function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b,
                                              input int n);
        logic signed [127:0] p, s, r;
        p = $signed({{64{a[XLEN-1]}}, a}) * $signed({{64{b[XLEN-1]}}, b});
        if (n == 0) return p[XLEN-1:0];
        s = p + (128'sd1 <<< (n - 1));
        r = s >>> n;
        return r[XLEN-1:0];
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on falling edge; compare the vector from the previous falling edge.
    task automatic step(input logic [XLEN-1:0] a1, input logic [XLEN-1:0] b1,
                        input logic [XLEN-1:0] a2, input logic [XLEN-1:0] b2,
                        input int n, input string req);
        @(negedge clk);
        if (exp_t_q.size() > 0) begin
            string t;
            t = tag_q.pop_front();
            check({t, " R2 rt"}, rt, exp_t_q.pop_front());
            check({t, " R2 rs"}, rs, exp_s_q.pop_front());
        end
        op1_a = a1; op1_b = b1; op2_a = a2; op2_b = b2;
        shamt = SHW'(n);
        exp_t_q.push_back(model(a1, b1, n));
        exp_s_q.push_back(model(a2, b2, n));
        tag_q.push_back(req);
    endtask

    function automatic logic [XLEN-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    localparam logic [XLEN-1:0] ONES = '1;
    localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};

    initial begin
        rst_n = 1'b0;
        op1_a = '1; op1_b = 64'd7; op2_a = 64'd5; op2_b = 64'd9; shamt = '0;
        repeat (3) @(negedge clk);
        check("R1 rt", rt, '0);
        check("R1 rs", rs, '0);
        @(negedge clk);
        rst_n = 1'b1;

        step(64'd12345, 64'd678, ONES, 64'd3, 0, "R3");
        step(ONES, ONES, 64'd0, rnd64(), 0, "R6");
        step(64'd1, 64'd1, 64'd3, 64'd1, 1, "R4");
        step(-64'sd3, 64'd1, ONES, 64'd1, 1, "R5");
        step(MINV, MINV, MINV, ONES, 63, "R6");
        step(MINV, MINV, MINV, MINV, 0, "R6");
        step(64'd5, 64'd7, 64'd5, 64'd7, 2, "R7");
        step(64'd0, rnd64(), rnd64(), 64'd0, 17, "R7");
        step(64'h7fff_ffff_ffff_ffff, 64'h7fff_ffff_ffff_ffff, -64'sd6, 64'd1, 2, "R4");
        for (int n = 0; n < XLEN; n++) begin
            for (int k = 0; k < 16; k++) begin
                step(rnd64(), rnd64(), rnd64(), rnd64(), n, "R8");
            end
        end
        step('0, '0, '0, '0, 0, "R3");
        @(negedge clk);
        check("R1 R2 final rt", rt, exp_t_q.pop_front());
        check("R1 R2 final rs", rs, exp_s_q.pop_front());
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule